// File: doc/BRIEF.md
# Byte-Synchronous Character Receiver

This block takes a serial bit stream, one bit per cycle in which the receive enable is high, and looks for a programmed synchronisation character at every bit position. After it finds one character, or two in a row in two-character mode, it is locked to character boundaries. From then on it collects every eight bits into a byte. It drops any synchronisation characters that come before the first real data byte. Each data byte goes into a four-entry receive queue, and a host pops that queue through a show-ahead read port.

Alongside the queue, every data byte is passed through a one-byte delay stage into a CRC-16 checker. When the host marks the end of a block, the held byte is fed through the checker and a status flag reports whether the remainder is zero. A sticky overrun flag records any byte that was lost because the queue was full. A status-read strobe clears both flags. A hunt command sends the receiver back to searching for the synchronisation character.

Top module: `bsr_rx`

## Requirements
- R1: After reset, `in_sync`, `rd_valid`, `overrun` and `crc_ok` are all 0.
- R2: In one-character mode (`two_syn`=0), `in_sync` rises on the enabled bit whose last eight received bits equal `syn_a`. Bits are taken first-received as the MSB, and this works at any bit alignment of the stream.
- R3: In two-character mode (`two_syn`=1), sync needs `syn_a` immediately followed by `syn_b` on the next eight bits. If any other value follows `syn_a`, the receiver goes back to searching and `in_sync` stays 0.
- R4: Once in sync, each following group of eight enabled bits forms one byte, with the first bit as MSB. Bytes equal to a synchronisation character in use are discarded until the first other byte arrives. After that, such values are kept as data.
- R5: The receive queue holds 4 bytes. `rd_valid` is 1 while it is non-empty, and `rd_data` shows the oldest byte. A one-cycle `rd` pulse removes that byte, so bytes come out in arrival order.
- R6: A data byte that arrives while the queue holds 4 bytes is discarded and sets `overrun`. The queued bytes are not changed.
- R7: The checker runs CRC-16 with polynomial 0x8005, MSB first, starting from zero on sync and after each end-of-block. It covers the data bytes. On an `eob` pulse, `crc_ok` becomes 1 if the remainder over the block's bytes, with the CRC bytes appended high byte first, is zero, and 0 otherwise.
- R8: A `stat_rd` pulse clears both `crc_ok` and `overrun`.
- R9: A `hunt` pulse drops `in_sync` on the next cycle. No bytes are assembled until a new synchronisation character is found.
- R10: `rx_bit` has no effect while `rx_en` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rx_en | input | 1 | Bit enable: `rx_bit` is taken in this cycle |
| rx_bit | input | 1 | Serial data bit |
| syn_a | input | 8 | First (or only) synchronisation character |
| syn_b | input | 8 | Second synchronisation character in two-character mode |
| two_syn | input | 1 | 1 selects two-character sync |
| hunt | input | 1 | Pulse: restart the synchronisation search |
| eob | input | 1 | Pulse: end of block, evaluate the CRC |
| stat_rd | input | 1 | Pulse: status read, clears `crc_ok` and `overrun` |
| rd | input | 1 | Pulse: pop the head of the receive queue |
| rd_data | output | 8 | Head of the receive queue |
| rd_valid | output | 1 | Receive queue not empty |
| in_sync | output | 1 | Character alignment acquired |
| overrun | output | 1 | Sticky: a byte was lost to a full queue |
| crc_ok | output | 1 | Last evaluated block had a zero remainder |

## Verification
The synchronisation character is sent after every number of filler bits from zero to seven. This shows whether the search really tests every bit position, or whether it only matches at one fixed phase. In two-character mode, a first character followed by the wrong second character is compared with the correct pair, to separate a true two-step match from a single-character match. A sweep of sixteen two-byte messages, each with its CRC appended, must report a good check. Single-bit corruptions of those messages must report a bad one, which shows whether the delay stage loses or repeats a byte. Five bytes sent into an unread queue, a hunt in the middle of a stream, and bit toggles with the enable low cover the overrun, restart and ignore paths.

// File: rtl/bsr_pkg.sv
package bsr_pkg;
    typedef enum logic [1:0] {
        ST_HUNT = 2'd0,
        ST_SYN2 = 2'd1,
        ST_SYNC = 2'd2
    } hunt_st_e;
endpackage

// File: rtl/bsr_hunt.sv
module bsr_hunt
    import bsr_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         rx_en,
    input  logic         rx_bit,
    input  logic [W-1:0] syn_a,
    input  logic [W-1:0] syn_b,
    input  logic         two_syn,
    input  logic         hunt,
    output logic         byte_v,
    output logic [W-1:0] byte_o,
    output logic         sync_start,
    output logic         in_sync
);
    localparam int CNTW = $clog2(W);
    localparam logic [CNTW-1:0] LAST = CNTW'(W - 1);

    typedef struct packed {
        logic [W-2:0]    front;
        hunt_st_e        state;
        logic [CNTW-1:0] cnt;
        logic            seen;
        logic            out_v;
        logic [W-1:0]    out_b;
        logic            start;
    } hunt_s;

    hunt_s q, d;
    logic [W-1:0] win;
    logic         is_syn;

    always_comb begin
        d        = q;
        d.out_v  = 1'b0;
        d.start  = 1'b0;
        win      = {q.front, rx_bit};
        is_syn   = (win == syn_a) || (two_syn && (win == syn_b));
        if (hunt) begin
            d.state = ST_HUNT;
            d.cnt   = '0;
            d.seen  = 1'b0;
        end else if (rx_en) begin
            d.front = win[W-2:0];
            case (q.state)
                ST_HUNT: begin
                    if (win == syn_a) begin
                        d.cnt = '0;
                        if (two_syn) begin
                            d.state = ST_SYN2;
                        end else begin
                            d.state = ST_SYNC;
                            d.seen  = 1'b0;
                            d.start = 1'b1;
                        end
                    end
                end
                ST_SYN2: begin
                    if (q.cnt == LAST) begin
                        d.cnt = '0;
                        if (win == syn_b) begin
                            d.state = ST_SYNC;
                            d.seen  = 1'b0;
                            d.start = 1'b1;
                        end else begin
                            d.state = ST_HUNT;
                        end
                    end else begin
                        d.cnt = q.cnt + 1'b1;
                    end
                end
                ST_SYNC: begin
                    if (q.cnt == LAST) begin
                        d.cnt = '0;
                        if (q.seen || !is_syn) begin
                            d.out_v = 1'b1;
                            d.out_b = win;
                            d.seen  = 1'b1;
                        end
                    end else begin
                        d.cnt = q.cnt + 1'b1;
                    end
                end
                default: d.state = ST_HUNT;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign byte_v     = q.out_v;
    assign byte_o     = q.out_b;
    assign sync_start = q.start;
    assign in_sync    = (q.state == ST_SYNC);

    // R4: a byte only leaves while aligned
    a_r4_byte_in_sync: assert property (@(posedge clk) disable iff (!rst_n)
        q.out_v |-> $past(q.state == ST_SYNC));
    // R9: hunt always returns to search
    a_r9_hunt_restart: assert property (@(posedge clk) disable iff (!rst_n)
        hunt |=> (q.state == ST_HUNT));
    // R3: second-character stage entered only in two-character mode
    a_r3_two_step: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.state == ST_SYN2) |-> $past(two_syn));
endmodule

// File: rtl/bsr_crc.sv
module bsr_crc #(
    parameter int            W    = 8,
    parameter int            CW   = 16,
    parameter logic [CW-1:0] POLY = 16'h8005
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         byte_v,
    input  logic [W-1:0] byte_i,
    input  logic         eob,
    input  logic         stat_rd,
    output logic         crc_ok
);
    typedef struct packed {
        logic [W-1:0]  dly;
        logic          dly_v;
        logic [CW-1:0] crc;
        logic          ok;
    } crc_s;

    crc_s q, d;
    logic [CW-1:0] fin;

    function automatic logic [CW-1:0] crc_step(logic [CW-1:0] c, logic [W-1:0] v);
        logic [CW-1:0] r;
        r = c;
        for (int i = W - 1; i >= 0; i--) begin
            if (r[CW-1] ^ v[i]) r = {r[CW-2:0], 1'b0} ^ POLY;
            else                r = {r[CW-2:0], 1'b0};
        end
        return r;
    endfunction

    always_comb begin
        d   = q;
        fin = q.dly_v ? crc_step(q.crc, q.dly) : q.crc;
        if (stat_rd) d.ok = 1'b0;
        if (clr) begin
            d.crc   = '0;
            d.dly_v = 1'b0;
        end else if (eob) begin
            d.ok    = (fin == '0);
            d.crc   = '0;
            d.dly_v = 1'b0;
        end else if (byte_v) begin
            if (q.dly_v) d.crc = crc_step(q.crc, q.dly);
            d.dly   = byte_i;
            d.dly_v = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign crc_ok = q.ok;

    // R7: the status only rises on an end-of-block
    a_r7_ok_on_eob: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.ok) |-> $past(eob));
    // R8: status read clears the flag
    a_r8_ok_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_rd && !eob) |=> !q.ok);
endmodule

// File: rtl/bsr_fifo.sv
module bsr_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] din,
    input  logic         pop,
    input  logic         ovr_clr,
    output logic [W-1:0] dout,
    output logic         nonempty,
    output logic         ovr
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [AW:0] FULL_CNT = (AW + 1)'(DEPTH);

    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] mem;
        logic [AW-1:0]           wp;
        logic [AW-1:0]           rp;
        logic [AW:0]             cnt;
        logic                    ovr;
    } fifo_s;

    fifo_s q, d;
    logic  do_push, do_pop, full;

    always_comb begin
        d       = q;
        full    = (q.cnt == FULL_CNT);
        do_push = push && !full;
        do_pop  = pop && (q.cnt != '0);
        if (ovr_clr) d.ovr = 1'b0;
        if (push && full) d.ovr = 1'b1;
        if (do_push) begin
            d.mem[q.wp] = din;
            d.wp        = q.wp + 1'b1;
        end
        if (do_pop) d.rp = q.rp + 1'b1;
        case ({do_push, do_pop})
            2'b10:   d.cnt = q.cnt + 1'b1;
            2'b01:   d.cnt = q.cnt - 1'b1;
            default: d.cnt = q.cnt;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign dout     = q.mem[q.rp];
    assign nonempty = (q.cnt != '0);
    assign ovr      = q.ovr;

    // R5: occupancy never exceeds the depth
    a_r5_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        q.cnt <= FULL_CNT);
    // R6: overrun only from a push into a full queue
    a_r6_overrun_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.ovr) |-> $past(push && q.cnt == FULL_CNT));
    // R6: a dropped byte leaves the queue full
    a_r6_full_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !pop && q.cnt == FULL_CNT) |=> (q.cnt == FULL_CNT));
endmodule

// File: rtl/bsr_rx.sv
module bsr_rx #(
    parameter int W     = 8,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         rx_en,
    input  logic         rx_bit,
    input  logic [W-1:0] syn_a,
    input  logic [W-1:0] syn_b,
    input  logic         two_syn,
    input  logic         hunt,
    input  logic         eob,
    input  logic         stat_rd,
    input  logic         rd,
    output logic [W-1:0] rd_data,
    output logic         rd_valid,
    output logic         in_sync,
    output logic         overrun,
    output logic         crc_ok
);
    logic         byte_v;
    logic [W-1:0] byte_w;
    logic         sync_start;

    bsr_hunt #(.W(W)) u_hunt (
        .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .rx_bit(rx_bit),
        .syn_a(syn_a), .syn_b(syn_b), .two_syn(two_syn), .hunt(hunt),
        .byte_v(byte_v), .byte_o(byte_w), .sync_start(sync_start),
        .in_sync(in_sync)
    );

    bsr_crc #(.W(W)) u_crc (
        .clk(clk), .rst_n(rst_n), .clr(sync_start || hunt),
        .byte_v(byte_v), .byte_i(byte_w), .eob(eob), .stat_rd(stat_rd),
        .crc_ok(crc_ok)
    );

    bsr_fifo #(.W(W), .DEPTH(DEPTH)) u_fifo (
        .clk(clk), .rst_n(rst_n), .push(byte_v), .din(byte_w), .pop(rd),
        .ovr_clr(stat_rd), .dout(rd_data), .nonempty(rd_valid), .ovr(overrun)
    );

    // R2: sync is gained only on an enabled bit
    a_r2_sync_on_bit: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(in_sync) |-> $past(rx_en));
    // R10: without enable or hunt the alignment state holds
    a_r10_idle_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (!rx_en && !hunt) |=> $stable(in_sync));
endmodule

// File: tb/bsr_rx_test.sv
`timescale 1ns/1ps
module bsr_rx_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx_en = 1'b0, rx_bit = 1'b0;
    logic [7:0] syn_a = 8'h16, syn_b = 8'h96;
    logic       two_syn = 1'b0, hunt = 1'b0, eob = 1'b0, stat_rd = 1'b0, rd = 1'b0;
    logic [7:0] rd_data;
    logic       rd_valid, in_sync, overrun, crc_ok;

    int checks = 0;
    int fails  = 0;

    always #2 clk = ~clk;

    bsr_rx uut (
        .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .rx_bit(rx_bit),
        .syn_a(syn_a), .syn_b(syn_b), .two_syn(two_syn), .hunt(hunt),
        .eob(eob), .stat_rd(stat_rd), .rd(rd), .rd_data(rd_data),
        .rd_valid(rd_valid), .in_sync(in_sync), .overrun(overrun), .crc_ok(crc_ok)
    );

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        idle(3);
        rst_n = 1'b1;
        idle(1);
    endtask

    task automatic send_bit(input logic b);
        @(negedge clk);
        rx_bit = b;
        rx_en  = 1'b1;
        @(negedge clk);
        rx_en  = 1'b0;
    endtask

    task automatic send_byte(input logic [7:0] v);
        for (int i = 7; i >= 0; i--) send_bit(v[i]);
    endtask

    task automatic pulse_hunt();
        hunt = 1'b1; @(negedge clk); hunt = 1'b0;
    endtask

    task automatic pulse_eob();
        eob = 1'b1; @(negedge clk); eob = 1'b0;
    endtask

    task automatic pulse_stat();
        stat_rd = 1'b1; @(negedge clk); stat_rd = 1'b0;
    endtask

    task automatic pop_chk(input string req, input logic [7:0] exp);
        chk(req, {15'd0, rd_valid}, 16'd1);
        chk(req, {8'd0, rd_data}, {8'd0, exp});
        rd = 1'b1; @(negedge clk); rd = 1'b0;
    endtask

    function automatic logic [15:0] crc_bytes(input logic [7:0] a, input logic [7:0] b);
        logic [15:0] r = 16'h0000;
        logic [15:0] m = {a, b};
        for (int i = 15; i >= 0; i--) begin
            logic top = r[15] ^ m[i];
            r = {r[14:0], 1'b0};
            if (top) r = r ^ 16'h8005;
        end
        return r;
    endfunction

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin : main
        do_reset();
        // R1: reset state
        chk("R1 in_sync", {15'd0, in_sync}, 16'd0);
        chk("R1 rd_valid", {15'd0, rd_valid}, 16'd0);
        chk("R1 overrun", {15'd0, overrun}, 16'd0);
        chk("R1 crc_ok", {15'd0, crc_ok}, 16'd0);

        // R2/R4/R5: every alignment offset in one-character mode
        for (int off = 0; off < 8; off++) begin
            logic [7:0] d1;
            d1 = 8'((off * 37) + 5);
            two_syn = 1'b0;
            do_reset();
            for (int k = 0; k < off; k++) send_bit(1'b1);
            idle(2);
            chk("R2 no early sync", {15'd0, in_sync}, 16'd0);
            send_byte(syn_a);
            idle(1);
            chk("R2 sync at offset", {15'd0, in_sync}, 16'd1);
            send_byte(syn_a);
            send_byte(d1);
            send_byte(syn_a);
            idle(3);
            pop_chk("R4 first data byte", d1);
            pop_chk("R4 later syn kept", syn_a);
            chk("R5 empty after pops", {15'd0, rd_valid}, 16'd0);
        end

        // R3: two-character mode
        two_syn = 1'b1;
        do_reset();
        send_byte(syn_a);
        idle(1);
        chk("R3 one char not enough", {15'd0, in_sync}, 16'd0);
        send_byte(8'h55);
        idle(1);
        chk("R3 wrong second char", {15'd0, in_sync}, 16'd0);
        send_byte(syn_a);
        send_byte(syn_b);
        idle(1);
        chk("R3 pair gives sync", {15'd0, in_sync}, 16'd1);
        send_byte(8'hC3);
        idle(3);
        pop_chk("R3 data after pair", 8'hC3);
        two_syn = 1'b0;

        // R7/R8/R5: CRC sweep with good and corrupted blocks
        for (int k = 0; k < 16; k++) begin
            logic [7:0]  m0, m1;
            logic [15:0] c;
            m0 = 8'((k * 17) + 1);
            m1 = 8'(k) ^ 8'h5A;
            c  = crc_bytes(m0, m1);
            do_reset();
            send_byte(syn_a);
            send_byte(m0);
            send_byte(m1);
            send_byte(c[15:8]);
            send_byte(c[7:0]);
            idle(3);
            pulse_eob();
            chk("R7 good block", {15'd0, crc_ok}, 16'd1);
            pulse_stat();
            chk("R8 crc_ok cleared", {15'd0, crc_ok}, 16'd0);
            pop_chk("R5 order 0", m0);
            pop_chk("R5 order 1", m1);
            pop_chk("R5 order 2", c[15:8]);
            pop_chk("R5 order 3", c[7:0]);
            send_byte(m0);
            send_byte(m1 ^ (8'h01 << (k % 8)));
            send_byte(c[15:8]);
            send_byte(c[7:0]);
            idle(3);
            pulse_eob();
            chk("R7 corrupted block", {15'd0, crc_ok}, 16'd0);
            for (int j = 0; j < 4; j++) begin
                rd = 1'b1; @(negedge clk); rd = 1'b0;
            end
        end

        // R6/R8: overrun
        do_reset();
        send_byte(syn_a);
        for (int j = 0; j < 5; j++) send_byte(8'(8'h10 + j));
        idle(3);
        chk("R6 overrun set", {15'd0, overrun}, 16'd1);
        for (int j = 0; j < 4; j++) pop_chk("R6 kept bytes", 8'(8'h10 + j));
        chk("R6 fifth byte dropped", {15'd0, rd_valid}, 16'd0);
        pulse_stat();
        chk("R8 overrun cleared", {15'd0, overrun}, 16'd0);

        // R9: hunt
        pulse_hunt();
        chk("R9 sync dropped", {15'd0, in_sync}, 16'd0);
        send_byte(8'h77);
        idle(3);
        chk("R9 no byte in search", {15'd0, rd_valid}, 16'd0);

        // R10: bits ignored without enable
        send_byte(syn_a);
        idle(1);
        chk("R10 resync", {15'd0, in_sync}, 16'd1);
        for (int j = 0; j < 16; j++) begin
            @(negedge clk);
            rx_bit = j[0];
        end
        idle(2);
        chk("R10 nothing queued", {15'd0, rd_valid}, 16'd0);
        send_byte(8'hA5);
        idle(3);
        pop_chk("R10 alignment kept", 8'hA5);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule